// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits beside an 8-bit processor core and decides when, and to where, the core is diverted by an interrupt. Requests arrive on two groups of lines. The "half" group has three lines that a three-bit mask register can hold off. The restart group has three lines that are never masked: keyboard, serial and vertical retrace. A rising edge on any request line sets a sticky pending bit, so a short pulse is kept while interrupts are disabled.

The core signals each instruction boundary. At a boundary where the enable flag is set and an eligible request is pending, the controller takes one source by fixed priority and clears only that source's pending bit. It clears the enable flag and raises a busy output that stalls instruction fetch. It then writes the current program counter onto the stack in two cycles, high byte first, updates the stack pointer, and presents the vector for the core to load. Any other requests stay pending and are serviced one at a time by later entries. The boundary that directly follows an enable instruction never accepts an entry, so an enable followed by a return completes with no interrupt between them.

Top module: `irq_restart_ctrl`

## Requirements
- R1: After reset the enable flag is 0, every half-interrupt line is masked (mask = 3'b111), no bit is pending, and busy, memory write, stack-pointer write and vector-valid are all 0.
- R2: An entry starts only at a cycle where boundary_i is 1, the enable flag is 1, the controller is not busy, the cycle is not under the enable shadow (R9), and at least one eligible request is pending. busy_o goes to 1 in the cycle after that boundary.
- R3: A half-interrupt bit is eligible only when its mask bit is 0 (mask bit 1 = held off). Restart bits are always eligible. A masked half bit stays pending and is serviced once its mask bit is written to 0 through mask_we_i/mask_data_i.
- R4: Among the eligible bits, priority is half bit 0, half bit 1, half bit 2, then restart bit 0, restart bit 1, restart bit 2.
- R5: The vectors are 0x2C, 0x34 and 0x3C for half bits 0, 1, 2, and 0x08, 0x10 and 0x20 for restart bits 0, 1, 2.
- R6: Each entry clears exactly the pending bit of the source it serves. Simultaneous requests lead to one entry each, in priority order, and never to a merged vector.
- R7: In the first busy cycle the block writes PC[15:8] to address SP-1. In the second busy cycle it writes PC[7:0] to address SP-2 and drives sp_we_o with the value SP-2. PC and SP are the values present at the accepting boundary.
- R8: The enable flag is 0 from the first busy cycle onward. busy_o stays high for exactly three cycles. vec_valid_o carries the vector in the third cycle.
- R9: The first boundary after an ei_i pulse never accepts an entry. A later boundary may accept one.
- R10: A request is captured on its rising edge and stays pending while the enable flag is clear. A line that is held high sets its pending bit only once.
- R11: ei_i sets the enable flag and di_i clears it. If both are 1 in the same cycle, the flag becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_req_i | input | 3 | Maskable half-interrupt request lines |
| rst_req_i | input | 3 | Restart request lines (keyboard, serial, retrace) |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 3 | New mask value (1 = held off) |
| ei_i | input | 1 | Enable instruction executed |
| di_i | input | 1 | Disable instruction executed |
| boundary_i | input | 1 | Core is at an instruction boundary |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| mem_we_o | output | 1 | Stack memory write strobe |
| mem_addr_o | output | 16 | Stack memory write address |
| mem_data_o | output | 8 | Stack memory write byte |
| sp_we_o | output | 1 | Stack pointer load strobe |
| sp_o | output | 16 | New stack pointer value |
| vec_valid_o | output | 1 | Load vec_o into the program counter |
| vec_o | output | 16 | Interrupt vector address |
| busy_o | output | 1 | Entry in progress, stall fetch |
| ie_o | output | 1 | Interrupt enable flag |

## Verification
Each result of an entry has a fixed cycle after the accepting boundary edge. busy_o and the cleared enable flag appear one cycle after it. The high-byte push appears in that same cycle, the low-byte push and stack-pointer load one cycle later, and the vector one cycle after that. A request edge becomes pending one cycle after it is sampled, and an ei_i pulse shows on ie_o one cycle later. The bench steps a behavioural reference through the same edges and compares every output at each falling clock edge, where no register is changing. Scenario checks sample busy_o just after a boundary pulse to see whether that boundary was taken or blocked, and compare the logged vector order against the priority list.

// File: rtl/irq_restart_pkg.sv
// Shared types and vector helpers for the restart interrupt controller.
// Assumes at most a handful of lines per group; the vector formulas cover them.
package irq_restart_pkg;

    // Phases of one interrupt entry
    typedef enum logic [1:0] {
        ENT_IDLE    = 2'd0,
        ENT_PUSH_HI = 2'd1,
        ENT_PUSH_LO = 2'd2,
        ENT_JUMP    = 2'd3
    } ent_state_t;

    // Half-interrupt vectors sit 8 bytes apart starting at 0x2C
    function automatic logic [15:0] half_vector(input int k);
        return 16'h002C + 16'(8 * k);
    endfunction

    // Restart vectors double per line starting at 0x08
    function automatic logic [15:0] rst_vector(input int k);
        return 16'h0008 << k;
    endfunction

endpackage

// File: rtl/irq_edge_pend.sv
// Rising-edge request capture into sticky pending bits.
// Assumes request lines are synchronous to clk. A clear and a new edge in the
// same cycle leave the bit set, so the new request is kept.
module irq_edge_pend #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] req_q;
    logic [W-1:0] pend_q;

    // Keep last request level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    // Set on rising edge, clear on service
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | (req_i & ~req_q);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_arb.sv
// Fixed-priority selector across the masked half group and the restart group.
// Half bits outrank restart bits and lower indices win within a group.
// Purely combinational; grants are one-hot or zero.
module irq_prio_arb
    import irq_restart_pkg::*;
#(
    parameter int NH = 3,
    parameter int NR = 3,
    parameter int AW = 16
) (
    input  logic [NH-1:0] half_pend_i,
    input  logic [NH-1:0] half_mask_i,
    input  logic [NR-1:0] rst_pend_i,
    output logic          any_o,
    output logic [NH-1:0] grant_h_o,
    output logic [NR-1:0] grant_r_o,
    output logic [AW-1:0] vec_o
);
    logic [NH-1:0] eligible;
    logic          taken;

    assign eligible = half_pend_i & ~half_mask_i;
    assign any_o    = (|eligible) | (|rst_pend_i);

    // Walk sources in priority order and grant the first one found
    always_comb begin
        grant_h_o = '0;
        grant_r_o = '0;
        vec_o     = '0;
        taken     = 1'b0;
        for (int k = 0; k < NH; k++) begin
            if (!taken && eligible[k]) begin
                grant_h_o[k] = 1'b1;
                vec_o        = AW'(half_vector(k));
                taken        = 1'b1;
            end
        end
        for (int k = 0; k < NR; k++) begin
            if (!taken && rst_pend_i[k]) begin
                grant_r_o[k] = 1'b1;
                vec_o        = AW'(rst_vector(k));
                taken        = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Entry sequencer: after an accept it pushes PC high then low byte and loads
// the vector, three busy cycles in total. It latches PC, SP and the vector at
// the accept so the core may change them while stalled.
module irq_entry_seq
    import irq_restart_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic [AW-1:0] vec_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] sp_i,
    output logic          idle_o,
    output logic          busy_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_data_o,
    output logic          sp_we_o,
    output logic [AW-1:0] sp_o,
    output logic          vec_valid_o,
    output logic [AW-1:0] vec_o
);
    ent_state_t    state_q;
    logic [AW-1:0] pc_q, sp_q, vec_q;

    // Advance through the push and jump phases
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_IDLE;
        else begin
            case (state_q)
                ENT_IDLE:    if (accept_i) state_q <= ENT_PUSH_HI;
                ENT_PUSH_HI: state_q <= ENT_PUSH_LO;
                ENT_PUSH_LO: state_q <= ENT_JUMP;
                default:     state_q <= ENT_IDLE;
            endcase
        end
    end

    // Hold the context of the accepted entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= '0;
            vec_q <= '0;
        end else if (accept_i && state_q == ENT_IDLE) begin
            pc_q  <= pc_i;
            sp_q  <= sp_i;
            vec_q <= vec_i;
        end
    end

    // Decode the bus outputs from the phase
    always_comb begin
        mem_we_o   = 1'b0;
        mem_addr_o = '0;
        mem_data_o = '0;
        if (state_q == ENT_PUSH_HI) begin
            mem_we_o   = 1'b1;
            mem_addr_o = sp_q - AW'(1);
            mem_data_o = pc_q[AW-1 -: DW];
        end else if (state_q == ENT_PUSH_LO) begin
            mem_we_o   = 1'b1;
            mem_addr_o = sp_q - AW'(2);
            mem_data_o = pc_q[DW-1:0];
        end
    end

    assign idle_o      = (state_q == ENT_IDLE);
    assign busy_o      = !idle_o;
    assign sp_we_o     = (state_q == ENT_PUSH_LO);
    assign sp_o        = sp_q - AW'(2);
    assign vec_valid_o = (state_q == ENT_JUMP);
    assign vec_o       = vec_valid_o ? vec_q : '0;
endmodule

// File: rtl/irq_restart_ctrl.sv
// Top of the restart interrupt controller. It holds the enable flag, the
// shadow that blocks the boundary after an enable, and the half-group mask,
// and it combines capture, arbitration and the entry sequencer.
// Assumes boundary_i is only raised while the core is not stalled.
module irq_restart_ctrl
    import irq_restart_pkg::*;
#(
    parameter int NH = 3,
    parameter int NR = 3,
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NH-1:0] half_req_i,
    input  logic [NR-1:0] rst_req_i,
    input  logic          mask_we_i,
    input  logic [NH-1:0] mask_data_i,
    input  logic          ei_i,
    input  logic          di_i,
    input  logic          boundary_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] sp_i,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_data_o,
    output logic          sp_we_o,
    output logic [AW-1:0] sp_o,
    output logic          vec_valid_o,
    output logic [AW-1:0] vec_o,
    output logic          busy_o,
    output logic          ie_o
);
    localparam int NS = NH + NR;

    logic          ie_q, shadow_q;
    logic [NH-1:0] mask_q;
    logic [NH-1:0] half_pend, clr_h, grant_h;
    logic [NR-1:0] rst_pend, clr_r, grant_r;
    logic [NS-1:0] grant_all;
    logic [AW-1:0] arb_vec;
    logic          any_req, idle, accept;

    irq_edge_pend #(.W(NH)) u_half_pend (
        .clk(clk), .rst_n(rst_n), .req_i(half_req_i), .clr_i(clr_h), .pend_o(half_pend)
    );

    irq_edge_pend #(.W(NR)) u_rst_pend (
        .clk(clk), .rst_n(rst_n), .req_i(rst_req_i), .clr_i(clr_r), .pend_o(rst_pend)
    );

    irq_prio_arb #(.NH(NH), .NR(NR), .AW(AW)) u_arb (
        .half_pend_i(half_pend), .half_mask_i(mask_q), .rst_pend_i(rst_pend),
        .any_o(any_req), .grant_h_o(grant_h), .grant_r_o(grant_r), .vec_o(arb_vec)
    );

    assign accept    = idle && boundary_i && ie_q && !shadow_q && any_req;
    assign clr_h     = accept ? grant_h : '0;
    assign clr_r     = accept ? grant_r : '0;
    assign grant_all = {grant_r, grant_h};

    irq_entry_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .vec_i(arb_vec),
        .pc_i(pc_i), .sp_i(sp_i), .idle_o(idle), .busy_o(busy_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
        .sp_we_o(sp_we_o), .sp_o(sp_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
    );

    // Enable flag: entry and disable win over enable
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (accept) ie_q <= 1'b0;
        else if (di_i)   ie_q <= 1'b0;
        else if (ei_i)   ie_q <= 1'b1;
    end

    // Shadow covers the first boundary after an enable
    always_ff @(posedge clk) begin
        if (!rst_n)          shadow_q <= 1'b0;
        else if (ei_i)       shadow_q <= 1'b1;
        else if (boundary_i) shadow_q <= 1'b0;
    end

    // Half-group mask register, all lines held off after reset
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_we_i) mask_q <= mask_data_i;
    end

    assign ie_o = ie_q;
endmodule

// File: rtl/irq_restart_ctrl_chk.sv
// Property checker for the restart interrupt controller, bound to the top.
module irq_restart_ctrl_chk
    import irq_restart_pkg::*;
#(
    parameter int NH = 3,
    parameter int NR = 3,
    parameter int AW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            boundary_i,
    input logic            ei_i,
    input logic            busy_o,
    input logic            ie_o,
    input logic            mem_we_o,
    input logic [AW-1:0]   mem_addr_o,
    input logic            sp_we_o,
    input logic            vec_valid_o,
    input logic [AW-1:0]   vec_o,
    input logic [NH+NR-1:0] grant
);
    logic ei_seen;
    logic vec_ok;

    // Track whether an enable is waiting for its first boundary
    always_ff @(posedge clk) begin
        if (!rst_n)          ei_seen <= 1'b0;
        else if (ei_i)       ei_seen <= 1'b1;
        else if (boundary_i) ei_seen <= 1'b0;
    end

    // Match the presented vector against the legal set
    always_comb begin
        vec_ok = 1'b0;
        for (int k = 0; k < NH; k++) if (vec_o == AW'(half_vector(k))) vec_ok = 1'b1;
        for (int k = 0; k < NR; k++) if (vec_o == AW'(rst_vector(k)))  vec_ok = 1'b1;
    end

    // R2
    entry_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(boundary_i) && $past(ie_o)));

    // R8
    ie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !ie_o);

    // R7
    push_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !sp_we_o) |=> (mem_we_o && sp_we_o && mem_addr_o == $past(mem_addr_o) - AW'(1)));

    // R8
    jump_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we_o |=> vec_valid_o);

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5
    vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> vec_ok);

    // R9
    ei_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && ei_seen) |=> !$rose(busy_o));
endmodule

bind irq_restart_ctrl irq_restart_ctrl_chk #(.NH(NH), .NR(NR), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ei_i(ei_i),
    .busy_o(busy_o), .ie_o(ie_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .sp_we_o(sp_we_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o), .grant(grant_all)
);

// File: tb/irq_restart_ctrl_tb_top.sv
// Bench: behavioural reference stepped every clock, outputs compared at negedge.
module irq_restart_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  half_req = '0, rst_req = '0, mask_data = '0;
    logic        mask_we = 1'b0, ei = 1'b0, di = 1'b0, bnd = 1'b0;
    logic [15:0] pc = 16'h0100, sp = 16'h2000;
    logic        mem_we, sp_we, vec_valid, busy, ie;
    logic [15:0] mem_addr, sp_o, vec;
    logic [7:0]  mem_data;

    int checks = 0, errors = 0, cycles = 0;
    logic [15:0] vlog[$];
    logic [23:0] wlog[$];
    logic [15:0] splog[$];

    always #10 clk = ~clk;

    irq_restart_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .half_req_i(half_req), .rst_req_i(rst_req),
        .mask_we_i(mask_we), .mask_data_i(mask_data), .ei_i(ei), .di_i(di),
        .boundary_i(bnd), .pc_i(pc), .sp_i(sp), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_data_o(mem_data), .sp_we_o(sp_we), .sp_o(sp_o),
        .vec_valid_o(vec_valid), .vec_o(vec), .busy_o(busy), .ie_o(ie)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st, m_hp, m_rp, m_mask, m_ie, m_sh, m_pc, m_sp, m_vec, m_hq, m_rq;
    int vtab[6] = '{'h2C, 'h34, 'h3C, 'h08, 'h10, 'h20};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_hp = 0; m_rp = 0; m_mask = 7; m_ie = 0; m_sh = 0;
            m_pc = 0; m_sp = 0; m_vec = 0; m_hq = 0; m_rq = 0;
        end else begin
            int cand, pick, acc;
            cand = (m_hp & ~m_mask & 7) | (m_rp << 3);
            acc  = (m_st == 0 && bnd && m_ie == 1 && m_sh == 0 && cand != 0) ? 1 : 0;
            pick = -1;
            for (int i = 5; i >= 0; i--) if (cand[i]) pick = i;
            if (acc == 1) begin
                m_vec = vtab[pick]; m_pc = pc; m_sp = sp; m_st = 1;
                if (pick < 3) m_hp = m_hp & ~(1 << pick);
                else          m_rp = m_rp & ~(1 << (pick - 3));
            end else if (m_st != 0) m_st = (m_st == 3) ? 0 : m_st + 1;
            m_hp = m_hp | (int'(half_req) & ~m_hq);
            m_rp = m_rp | (int'(rst_req) & ~m_rq);
            m_hq = int'(half_req); m_rq = int'(rst_req);
            if (acc == 1)   m_ie = 0;
            else if (di)    m_ie = 0;
            else if (ei)    m_ie = 1;
            if (ei)         m_sh = 1;
            else if (bnd)   m_sh = 0;
            if (mask_we)    m_mask = int'(mask_data);
        end
    end

    // Per-cycle comparison and logging at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 busy", busy, m_st != 0);
            chk("R11 ie", ie, m_ie[0]);
            chk("R7 mem_we", mem_we, m_st == 1 || m_st == 2);
            chk("R7 sp_we", sp_we, m_st == 2);
            chk("R8 vec_valid", vec_valid, m_st == 3);
            if (m_st == 1) begin
                chk("R7 addr hi", mem_addr, 16'(m_sp - 1));
                chk("R7 data hi", mem_data, 8'(m_pc >> 8));
            end
            if (m_st == 2) begin
                chk("R7 addr lo", mem_addr, 16'(m_sp - 2));
                chk("R7 data lo", mem_data, 8'(m_pc));
                chk("R7 sp", sp_o, 16'(m_sp - 2));
            end
            if (m_st == 3) chk("R5 vector", vec, 16'(m_vec));
            if (vec_valid) vlog.push_back(vec);
            if (mem_we) wlog.push_back({mem_addr, mem_data});
            if (sp_we) splog.push_back(sp_o);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ei();
        @(negedge clk); ei = 1'b1; @(negedge clk); ei = 1'b0;
    endtask

    task automatic boundary();
        @(negedge clk); bnd = 1'b1; @(negedge clk); bnd = 1'b0;
    endtask

    task automatic req(input logic [2:0] h, input logic [2:0] r);
        @(negedge clk); half_req = h; rst_req = r; @(negedge clk); half_req = '0; rst_req = '0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        @(negedge clk); mask_we = 1'b1; mask_data = m; @(negedge clk); mask_we = 1'b0;
    endtask

    // Enable, blocked boundary, then the boundary that may accept
    task automatic service(input logic exp_entry, input string tag);
        pulse_ei();
        boundary();
        chk("R9 shadow blocks first boundary", busy, 1'b0);
        boundary();
        chk(tag, busy, exp_entry);
        if (exp_entry) chk("R8 ie cleared on entry", ie, 1'b0);
        cyc(4);
    endtask

    task automatic chk_vlog(input string tag, input logic [15:0] exp[$]);
        chk({tag, " count"}, vlog.size(), exp.size());
        foreach (exp[i]) if (i < vlog.size()) chk(tag, vlog[i], exp[i]);
        vlog.delete();
    endtask

    initial begin
        cyc(3);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        chk("R1 ie", ie, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 mem_we", mem_we, 1'b0);
        chk("R1 sp_we", sp_we, 1'b0);
        chk("R1 vec_valid", vec_valid, 1'b0);
        // R1/R3: half line masked after reset, no entry
        req(3'b001, 3'b000);
        service(1'b0, "R1 masked after reset");
        set_mask(3'b000);
        service(1'b1, "R3 unmask releases half0");
        chk_vlog("R3 half0 vector", '{16'h002C});

        // R4 R5 R6 R10: all six at once while disabled
        req(3'b111, 3'b111);
        cyc(5);
        for (int i = 0; i < 6; i++) service(1'b1, "R10 captured entry");
        service(1'b0, "R6 nothing left pending");
        chk_vlog("R4 priority order", '{16'h002C, 16'h0034, 16'h003C, 16'h0008, 16'h0010, 16'h0020});

        // R3: masked half1 waits, restart2 served
        set_mask(3'b010);
        req(3'b010, 3'b100);
        service(1'b1, "R3 restart unmasked");
        service(1'b0, "R3 masked half stays off");
        set_mask(3'b000);
        service(1'b1, "R3 pending half after unmask");
        chk_vlog("R3 vectors", '{16'h0020, 16'h0034});

        // R10: held level captured once
        @(negedge clk); rst_req = 3'b001;
        service(1'b1, "R10 held level first");
        service(1'b0, "R10 held level no retrigger");
        @(negedge clk); rst_req = 3'b000;
        chk_vlog("R10 vector", '{16'h0008});

        // R7: stack contents for a chosen PC and SP
        pc = 16'h1234; sp = 16'h8000;
        wlog.delete(); splog.delete();
        req(3'b000, 3'b010);
        service(1'b1, "R7 entry");
        chk("R7 writes", wlog.size(), 2);
        if (wlog.size() == 2) begin
            chk("R7 first write", wlog[0], 24'h7FFF12);
            chk("R7 second write", wlog[1], 24'h7FFE34);
        end
        chk("R7 sp loads", splog.size(), 1);
        if (splog.size() == 1) chk("R7 new sp", splog[0], 16'h7FFE);
        chk_vlog("R5 serial vector", '{16'h0010});

        // R11: enable/disable
        pulse_ei();
        chk("R11 ei sets", ie, 1'b1);
        @(negedge clk); di = 1'b1; @(negedge clk); di = 1'b0;
        chk("R11 di clears", ie, 1'b0);
        @(negedge clk); ei = 1'b1; di = 1'b1; @(negedge clk); ei = 1'b0; di = 1'b0;
        chk("R11 di wins", ie, 1'b0);

        // R2: boundary with enable clear accepts nothing
        req(3'b000, 3'b100);
        boundary(); boundary();
        chk("R2 no entry while disabled", busy, 1'b0);
        service(1'b1, "R2 entry once enabled");
        chk_vlog("R2 vector", '{16'h0020});

        cyc(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule